// File: doc/BRIEF.md
# E1 Receive Line Decoder with Violation Flagging

This block sits behind the clock and data recovery of an E1 receiver. Each cycle of the recovered clock carries one bit position. For that position it receives two strobes, one for a positive mark and one for a negative mark. In single-rail operation it turns the bipolar stream back into NRZ data, using either plain AMI or HDB3 zero substitution. A second output flags coding errors. In dual-rail operation the two strobes pass straight through to the two outputs.

The output side picks the clock edge and the polarity that the terminal equipment expects. It can also silence the receive interface when the line is lost. An alarm test input forces the alarm outputs without touching the data. Every bit position, in every mode, takes the same number of clock cycles through the block. A substitution can therefore be removed after the fact, once its closing mark has been seen.

Top module: `e1rx_decoder`

## Requirements
- R1: A bit position sampled on rising edge n reaches the data outputs on rising edge n+3 in the rising-edge variant, or on the falling edge that follows it in the falling-edge variant (default substitution length 4). After reset the history is empty, so the outputs show zero data.
- R2: With dual_rail_i=0 and hdb3_i=1, a mark is a legal substitution mark when all of these hold: its polarity equals that of the previous mark, at least two mark-free positions come straight before it, and its polarity differs from the previous legal substitution mark (or no such mark has been seen). It decodes to 0, and so does the position three places earlier.
- R3: In HDB3 mode, a same-polarity mark that fails the spacing rule or the alternation rule raises rneg_viol_o for exactly the one bit period of that mark, and the mark decodes to 1.
- R4: With dual_rail_i=0 and hdb3_i=0 (AMI), every mark whose polarity equals the previous mark raises rneg_viol_o for its bit period and decodes to 1, however many zeros lie between them.
- R5: In single-rail mode, a position with both strobes high decodes to 1 and is flagged. It does not change the remembered mark polarity.
- R6: With dual_rail_i=1, rx_pos_i is reproduced on rdata_o and rx_neg_i on rneg_viol_o, with no decoding and no flags.
- R7: With if_sel_i=0, or in single-rail mode, the outputs are active-high and change on the falling clock edge. With if_sel_i=1 in dual-rail mode, they are active-low and change on the rising edge.
- R8: With mute_en_i=1 and los_ni=0, clk_lost_no is 0. In dual-rail mode with if_sel_i=0, rclk_o=1 and both data outputs are 0. In dual-rail mode with if_sel_i=1, rclk_o=0 and both data outputs are 1. In single-rail mode, rclk_o=1 and both outputs are 0. With mute_en_i=0, loss of signal changes neither the clock nor the data.
- R9: With alarm_test_ni=0, los_no and clk_lost_no are 0 and rneg_viol_o is 1, while rdata_o keeps carrying the normal data. Otherwise los_no follows los_ni.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Recovered receive clock, one bit position per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_pos_i | input | 1 | Positive mark strobe for the current position |
| rx_neg_i | input | 1 | Negative mark strobe for the current position |
| dual_rail_i | input | 1 | 1 selects dual-rail pass-through, 0 selects single-rail decoding |
| hdb3_i | input | 1 | In single-rail mode: 1 selects HDB3, 0 selects AMI |
| if_sel_i | input | 1 | Interface select for output edge and polarity |
| mute_en_i | input | 1 | Enables muting on loss of signal |
| los_ni | input | 1 | Loss of signal from the analog detector, active low |
| alarm_test_ni | input | 1 | Alarm test override, active low |
| rclk_o | output | 1 | Receive clock to the terminal equipment |
| rdata_o | output | 1 | Decoded data (single rail) or positive rail (dual rail) |
| rneg_viol_o | output | 1 | Violation flag (single rail) or negative rail (dual rail) |
| los_no | output | 1 | Loss of signal indication, active low |
| clk_lost_no | output | 1 | Loss of clock indication, active low |

## Verification
The decoder is driven with HDB3 streams built by an encoder in the bench from random data with frequent long zero runs. These streams exercise both substitution forms and must decode cleanly with no flags. Hand-built HDB3 streams add a closely spaced repeat mark and a substitution that repeats the previous substitution's polarity, which separates spacing errors from alternation errors. AMI runs pair legal alternating streams with a repeat mark after a long zero run and a double-strobe position, showing that AMI, unlike HDB3, excuses no repeat. Dual-rail runs with independent random rails are sampled just after each rising edge as well as late in the cycle, which tells the two output edge variants apart; the muting and alarm runs reuse these streams.

// File: rtl/e1rx_pkg.sv
package e1rx_pkg;

   // polarity of a received mark
   typedef enum logic {
      POL_NEG = 1'b0,
      POL_POS = 1'b1
   } mark_pol_e;

   // value forced on clock and data while the interface is muted
   function automatic logic mute_level(input logic rise_variant);
      return rise_variant;
   endfunction

endpackage

// File: rtl/e1rx_pipe.sv
module e1rx_pipe #(
   parameter int DEPTH  = 4,
   parameter int CLR_AT = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic din_i,
   input  logic clr_i,
   output logic dout_o
);

   logic st [DEPTH];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st[0] <= 1'b0;
      else         st[0] <= din_i;
   end

   for (genvar g = 1; g < DEPTH; g++) begin : g_stage
      if (g - 1 == CLR_AT) begin : g_clear
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) st[g] <= 1'b0;
            else         st[g] <= st[g-1] & ~clr_i;
         end

         // R2: a clear request removes the marked position on the next edge
         p_clear_pos_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            clr_i |=> !st[g]);
      end else begin : g_plain
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) st[g] <= 1'b0;
            else         st[g] <= st[g-1];
         end
      end
   end

   assign dout_o = st[DEPTH-1];

endmodule

// File: rtl/e1rx_linedec.sv
module e1rx_linedec
   import e1rx_pkg::*;
#(
   parameter int ZERO_RUN = 4
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic pos_i,
   input  logic neg_i,
   input  logic single_i,
   input  logic hdb3_i,
   output logic mark_o,
   output logic flag_o,
   output logic vclr_o
);

   localparam int GAP_MIN = ZERO_RUN - 2;
   localparam int ZW      = $clog2(ZERO_RUN + 1);
   localparam logic [ZW-1:0] ZCAP = ZW'(ZERO_RUN);
   localparam logic [ZW-1:0] ZGAP = ZW'(GAP_MIN);

   mark_pol_e     last_pol, last_vpol;
   logic          have_mark, have_v;
   logic [ZW-1:0] zcnt;

   logic      any_m, both_m, same_m, legal_v;
   mark_pol_e cur_pol;

   always_comb begin
      any_m   = pos_i | neg_i;
      both_m  = pos_i & neg_i;
      cur_pol = pos_i ? POL_POS : POL_NEG;
      same_m  = have_mark && any_m && !both_m && (cur_pol == last_pol);
      legal_v = hdb3_i && same_m && (zcnt >= ZGAP) &&
                (!have_v || (cur_pol != last_vpol));
      mark_o  = any_m && !legal_v;
      flag_o  = single_i && (both_m || (same_m && !legal_v));
      vclr_o  = single_i && legal_v;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         last_pol  <= POL_NEG;
         last_vpol <= POL_NEG;
         have_mark <= 1'b0;
         have_v    <= 1'b0;
         zcnt      <= '0;
      end else if (single_i) begin
         if (any_m && !both_m) begin
            last_pol  <= cur_pol;
            have_mark <= 1'b1;
         end
         if (legal_v) begin
            last_vpol <= cur_pol;
            have_v    <= 1'b1;
         end
         if (any_m)            zcnt <= '0;
         else if (zcnt != ZCAP) zcnt <= zcnt + 1'b1;
      end
   end

   // R2: a legal substitution mark always follows a mark-free position
   p_sub_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vclr_o |-> (!$past(pos_i) && !$past(neg_i)));

endmodule

// File: rtl/e1rx_outstage.sv
module e1rx_outstage
   import e1rx_pkg::*;
(
   input  logic clk_i,
   input  logic rst_ni,
   input  logic a_i,
   input  logic b_i,
   input  logic dual_i,
   input  logic sel_i,
   input  logic mute_en_i,
   input  logic los_ni,
   input  logic atm_ni,
   output logic rclk_o,
   output logic pos_o,
   output logic neg_o,
   output logic los_no,
   output logic lost_no
);

   logic an, bn;
   logic rise_v, muted, alarm, lvl;

   always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         an <= 1'b0;
         bn <= 1'b0;
      end else begin
         an <= a_i;
         bn <= b_i;
      end
   end

   always_comb begin
      rise_v  = dual_i & sel_i;
      muted   = mute_en_i & ~los_ni;
      alarm   = ~atm_ni;
      lvl     = mute_level(rise_v);
      rclk_o  = muted ? ~lvl : clk_i;
      pos_o   = muted ? lvl : (rise_v ? ~a_i : an);
      neg_o   = alarm ? 1'b1 : (muted ? lvl : (rise_v ? ~b_i : bn));
      los_no  = alarm ? 1'b0 : los_ni;
      lost_no = ~(alarm | muted);
   end

   // R7: the falling-edge copy holds what the rising-edge stage launched
   p_half_cycle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (an == a_i) && (bn == b_i));

   // R8: a settled mute freezes clock and data outputs
   p_mute_still_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (muted && $past(muted) && $stable(rise_v)) |-> ($stable(rclk_o) && $stable(pos_o)));

endmodule

// File: rtl/e1rx_decoder.sv
module e1rx_decoder #(
   parameter int ZERO_RUN = 4
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic rx_pos_i,
   input  logic rx_neg_i,
   input  logic dual_rail_i,
   input  logic hdb3_i,
   input  logic if_sel_i,
   input  logic mute_en_i,
   input  logic los_ni,
   input  logic alarm_test_ni,
   output logic rclk_o,
   output logic rdata_o,
   output logic rneg_viol_o,
   output logic los_no,
   output logic clk_lost_no
);

   localparam int DEPTH  = ZERO_RUN;
   localparam int CLR_AT = ZERO_RUN - 2;

   if (ZERO_RUN < 3 || ZERO_RUN > 8) begin : g_bad_run
      $error("e1rx_decoder: ZERO_RUN must lie in 3..8");
   end

   logic single, mark, flag, vclr;
   logic a_in, b_in, a_q, b_q;

   assign single = ~dual_rail_i;

   e1rx_linedec #(.ZERO_RUN(ZERO_RUN)) u_dec (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .pos_i    (rx_pos_i),
      .neg_i    (rx_neg_i),
      .single_i (single),
      .hdb3_i   (hdb3_i),
      .mark_o   (mark),
      .flag_o   (flag),
      .vclr_o   (vclr)
   );

   assign a_in = single ? mark : rx_pos_i;
   assign b_in = single ? flag : rx_neg_i;

   e1rx_pipe #(.DEPTH(DEPTH), .CLR_AT(CLR_AT)) u_pipe_a (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .din_i  (a_in),
      .clr_i  (vclr),
      .dout_o (a_q)
   );

   e1rx_pipe #(.DEPTH(DEPTH), .CLR_AT(CLR_AT)) u_pipe_b (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .din_i  (b_in),
      .clr_i  (1'b0),
      .dout_o (b_q)
   );

   e1rx_outstage u_out (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .a_i       (a_q),
      .b_i       (b_q),
      .dual_i    (dual_rail_i),
      .sel_i     (if_sel_i),
      .mute_en_i (mute_en_i),
      .los_ni    (los_ni),
      .atm_ni    (alarm_test_ni),
      .rclk_o    (rclk_o),
      .pos_o     (rdata_o),
      .neg_o     (rneg_viol_o),
      .los_no    (los_no),
      .lost_no   (clk_lost_no)
   );

endmodule

// File: tb/e1rx_decoder_test.sv
module e1rx_decoder_test;

   localparam int PERIOD = 10;

   logic clk = 1'b0;
   always #(PERIOD/2) clk = ~clk;

   logic rst_n, pos, neg, dual, hdb3, sel, mute, los, atm;
   logic rclk_o, rdata_o, rneg_o, los_no, lost_no;

   e1rx_decoder uut (
      .clk_i(clk), .rst_ni(rst_n), .rx_pos_i(pos), .rx_neg_i(neg),
      .dual_rail_i(dual), .hdb3_i(hdb3), .if_sel_i(sel), .mute_en_i(mute),
      .los_ni(los), .alarm_test_ni(atm), .rclk_o(rclk_o), .rdata_o(rdata_o),
      .rneg_viol_o(rneg_o), .los_no(los_no), .clk_lost_no(lost_no)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;
   logic sp [128];
   logic sn [128];
   logic ea [128];
   logic eb [128];
   int len;

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic ga(input int i);
      return (i < 0 || i > 127) ? 1'b0 : ea[i];
   endfunction

   function automatic logic gb(input int i);
      return (i < 0 || i > 127) ? 1'b0 : eb[i];
   endfunction

   task automatic clear_seq();
      for (int i = 0; i < 128; i++) begin
         sp[i] = 0; sn[i] = 0; ea[i] = 0; eb[i] = 0;
      end
      len = 0;
   endtask

   // code: 0 none, 1 positive, 2 negative, 3 both
   task automatic put(input int i, input int code, input logic d, input logic f);
      sp[i] = (code == 1 || code == 3);
      sn[i] = (code == 2 || code == 3);
      ea[i] = d;
      eb[i] = f;
   endtask

   task automatic do_reset();
      pos = 0; neg = 0; rst_n = 0;
      repeat (2) @(posedge clk);
      #3 rst_n = 1;
   endtask

   task automatic run_seq(input string rd, input string rv);
      logic rise, muted, fclk, fdat;
      rise  = dual & sel;
      muted = mute & ~los;
      fclk  = rise ? 1'b0 : 1'b1;
      fdat  = rise ? 1'b1 : 1'b0;
      pos = sp[0]; neg = sn[0];
      for (int c = 0; c < len + 4; c++) begin
         @(posedge clk);
         #2;
         if (muted) begin
            chk("R8 clock high phase", rclk_o, fclk);
            chk("R8 data early", rdata_o, fdat);
            if (atm) chk("R8 neg early", rneg_o, fdat);
         end else begin
            chk("R7 clock high phase", rclk_o, 1'b1);
            chk("R7 data edge", rdata_o, rise ? ~ga(c-3) : ga(c-4));
            if (atm) chk("R7 neg edge", rneg_o, rise ? ~gb(c-3) : gb(c-4));
         end
         #6;
         chk(muted ? "R8 clock low phase" : "R7 clock low phase", rclk_o, muted ? fclk : 1'b0);
         chk(muted ? "R8 data" : rd, rdata_o, muted ? fdat : (rise ? ~ga(c-3) : ga(c-3)));
         if (!atm)      chk("R9 neg forced", rneg_o, 1'b1);
         else if (muted) chk("R8 neg", rneg_o, fdat);
         else            chk(rv, rneg_o, rise ? ~gb(c-3) : gb(c-3));
         chk("R9 los out", los_no, atm ? los : 1'b0);
         chk(!atm ? "R9 clock lost" : "R8 clock lost", lost_no, !(!atm || muted));
         pos = (c + 1 < 128) ? sp[c+1] : 1'b0;
         neg = (c + 1 < 128) ? sn[c+1] : 1'b0;
      end
   endtask

   task automatic build_hdb3(input int n);
      logic lastp;
      int np, i;
      clear_seq();
      for (int k = 0; k < n; k++) ea[k] = (($urandom % 3) == 0);
      lastp = 0; np = 0; i = 0;
      while (i < n) begin
         if (i + 3 < n && !ea[i] && !ea[i+1] && !ea[i+2] && !ea[i+3]) begin
            if (np % 2 == 1) begin
               sp[i+3] = lastp; sn[i+3] = ~lastp;
            end else begin
               lastp = ~lastp;
               sp[i] = lastp; sn[i] = ~lastp;
               sp[i+3] = lastp; sn[i+3] = ~lastp;
            end
            np = 0; i += 4;
         end else begin
            if (ea[i]) begin
               lastp = ~lastp; sp[i] = lastp; sn[i] = ~lastp; np++;
            end
            i++;
         end
      end
      len = n;
   endtask

   task automatic build_ami(input int n);
      logic lastp;
      clear_seq();
      lastp = 0;
      for (int k = 0; k < n; k++) begin
         ea[k] = (($urandom % 2) == 0);
         if (ea[k]) begin lastp = ~lastp; sp[k] = lastp; sn[k] = ~lastp; end
      end
      len = n;
   endtask

   task automatic build_dual(input int n);
      clear_seq();
      for (int k = 0; k < n; k++) begin
         sp[k] = $urandom % 2; sn[k] = $urandom % 2;
         ea[k] = sp[k]; eb[k] = sn[k];
      end
      len = n;
   endtask

   initial begin
      dual = 0; hdb3 = 1; sel = 0; mute = 0; los = 1; atm = 1;
      pos = 0; neg = 0; rst_n = 0;
      #(PERIOD + 3);
      chk("R1 reset data", rdata_o, 1'b0);
      chk("R1 reset neg", rneg_o, 1'b0);
      chk("R1 reset los", los_no, 1'b1);
      chk("R1 reset clock lost", lost_no, 1'b1);

      // R1 R2: encoded HDB3 decodes cleanly
      do_reset(); build_hdb3(100); run_seq("R2 hdb3 data", "R2 no flag");
      do_reset(); build_hdb3(100); run_seq("R1 hdb3 data", "R2 no flag");

      // R3: spacing error at 3, alternation error at 14
      do_reset(); clear_seq();
      put(0,1,1,0); put(1,2,1,0); put(3,2,1,1); put(4,1,1,0);
      put(8,1,0,0); put(9,2,1,0); put(10,1,1,0); put(14,1,1,1);
      len = 20;
      run_seq("R3 data", "R3 flag");

      // R4: AMI clean stream
      hdb3 = 0;
      do_reset(); build_ami(90); run_seq("R4 ami data", "R4 no flag");
      // R4 R5: repeat after long gap, then double strobe
      do_reset(); clear_seq();
      put(0,1,1,0); put(4,1,1,1); put(5,2,1,0); put(6,3,1,1);
      put(7,1,1,0); put(8,2,1,0);
      len = 12;
      run_seq("R5 ami data", "R5 ami flag");

      // R6 R7: dual rail, both edge variants
      dual = 1;
      do_reset(); build_dual(80); run_seq("R6 pos rail", "R6 neg rail");
      sel = 1;
      do_reset(); build_dual(80); run_seq("R7 pos rail inverted", "R7 neg rail inverted");

      // R8: loss of signal without mute has no effect
      los = 0;
      do_reset(); build_dual(30); run_seq("R8 unmuted data", "R8 unmuted neg");
      // R8: muted, dual sel high, dual sel low, single rail
      mute = 1;
      do_reset(); build_dual(20); run_seq("R8 muted", "R8 muted");
      sel = 0;
      do_reset(); build_dual(20); run_seq("R8 muted", "R8 muted");
      dual = 0; hdb3 = 1;
      do_reset(); build_hdb3(20); run_seq("R8 muted", "R8 muted");

      // R9: alarm test keeps data flowing
      mute = 0; los = 1; atm = 0;
      do_reset(); build_hdb3(60); run_seq("R9 data kept", "R9 neg");
      dual = 1;
      do_reset(); build_dual(30); run_seq("R9 data kept dual", "R9 neg");

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(PERIOD * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule